// File: doc/BRIEF.md
# Multiplexed-Bus Address Latch and Chip-Select Decoder

This block sits beside a microcontroller whose address and data share one set of pins. While the address strobe is high, the block captures the bus value as the current address. It keeps that value steady while the strobe is low, so the bus pins are free to carry data. The captured address is split into three regions: external RAM at the bottom, an eight-byte internal register window just above it, and program ROM across the rest of the space. Each region gets its own active-low enable. The ROM address is widened to 18 bits by prefixing two bank bits that the controller drives from its own port pins. Together these reach four 64 KiB banks.

Inside the register window, a read strobe and a write strobe move bytes between the low half of the bus and four registers. The registers are a read/write configuration byte, a read-only counter byte, a serial byte (writes load the transmit side and reads return the receive side), and a read-only status byte. The counter, receive and status values come from neighbouring logic as inputs. The read path is registered and comes with a drive-enable, which gates the pad's tristate buffer.

Everything is synchronous to one clock with an active-high synchronous reset. The strobes are sampled on the clock, so the address latch, the enables and the read data appear one clock edge after the input that causes them.

Top module: `mux_bus_decoder`

## Requirements
- R1: While `ale` is high at a clock edge, `mem_addr` takes the value of `ad_in` at that edge. While `ale` is low, `mem_addr` keeps its value whatever `ad_in` does.
- R2: A latched address from 0x0000 to 0x1FF7 drives `ram_ce_n` low, with `rom_ce_n` and `win_ce_n` high. The enables change on the same edge as `mem_addr`.
- R3: A latched address from 0x1FF8 to 0x1FFF drives `win_ce_n` low, with the other two enables high. The window offset is address bits [2:0].
- R4: A latched address from 0x2000 to 0xFFFF drives `rom_ce_n` low, with the other two enables high. At most one enable is ever low.
- R5: At each clock edge, `rom_addr` becomes `{bank_sel, address}`: `bank_sel` forms bits [17:16] and the current address forms bits [15:0].
- R6: After reset, all three enables are high, `dout_oe` is 0, and `cfg_out` and `tx_out` are 0x00. The enables stay high until `ale` has been seen high once.
- R7: A write happens only on the first clock edge where `wr_en` is found high after being low, and only while the window is selected. That edge stores `ad_in[7:0]` into configuration at offset 0, or into transmit at offset 1. Holding `wr_en` high writes nothing more.
- R8: A write has no effect when the window is not selected, or when it targets offset 2 (counter), offset 3 (status) or offsets 4 to 7.
- R9: When `rd_en` is high at an edge while the window is selected, `dout_oe` is 1 after that edge. `dout` then holds configuration (offset 0), `rx_in` (offset 1), `cnt_in` (offset 2), `stat_in` (offset 3), or 0x00 (offsets 4 to 7).
- R10: `dout_oe` is 0 after any edge where `rd_en` is low or the window is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; address valid on `ad_in` while high |
| ad_in | input | 16 | Shared address/data bus as seen by the block |
| rd_en | input | 1 | Register read strobe, active high |
| wr_en | input | 1 | Register write strobe, active high; acts on its rising edge |
| bank_sel | input | 2 | ROM bank bits from controller port pins |
| cnt_in | input | 8 | Counter byte returned at offset 2 |
| rx_in | input | 8 | Serial receive byte returned at offset 1 |
| stat_in | input | 8 | Status byte returned at offset 3 |
| mem_addr | output | 16 | Latched address |
| rom_addr | output | 18 | Banked ROM address |
| ram_ce_n | output | 1 | RAM enable, active low |
| rom_ce_n | output | 1 | ROM enable, active low |
| win_ce_n | output | 1 | Register window enable, active low |
| dout | output | 8 | Register read data |
| dout_oe | output | 1 | Bus drive enable for `dout`; pad is high-impedance when 0 |
| cfg_out | output | 8 | Configuration register contents |
| tx_out | output | 8 | Serial transmit register contents |

## Verification
The bench targets the region edges 0x1FF7/0x1FF8 and 0x1FFF/0x2000, plus 0x0000 and 0xFFFF. A comparison off by one would light the wrong enable or two enables at once. It changes `ad_in` while `ale` is low and while `wr_en` is held high. A transparent latch would then corrupt `mem_addr`, and a level-sensitive write would store the later byte. It writes and reads the read-only and unused offsets and strobes outside the window. A decoder with loose offset or window gating would then change `cfg_out`/`tx_out`, return stale data, or raise `dout_oe`. Random addresses and bank bits are compared against a bench model of the map.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_WIN  = 2'd2,
    RGN_ROM  = 2'd3
  } region_e;

  typedef struct packed {
    logic ram;
    logic win;
    logic rom;
  } sel_t;

  function automatic sel_t region_to_sel(input region_e r);
    sel_t s;
    s.ram = (r == RGN_RAM);
    s.win = (r == RGN_WIN);
    s.rom = (r == RGN_ROM);
    return s;
  endfunction

endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic [ADDR_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_next,
  output logic              seen_next
);

  logic seen_q;

  // Next address: follow the bus under the strobe, otherwise hold.
  assign addr_next = ale ? bus_in : addr_q;
  assign seen_next = seen_q | ale;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      seen_q <= 1'b0;
    end else begin
      addr_q <= addr_next;
      seen_q <= seen_next;
    end
  end

endmodule

// File: rtl/mbd_map_decode.sv
module mbd_map_decode
  import mux_bus_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          BANK_W   = 2,
  parameter int          WIN_AW   = 3,
  parameter logic [15:0] WIN_BASE = 16'h1FF8,
  parameter logic [15:0] ROM_BASE = 16'h2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr_next,
  input  logic                     seen_next,
  input  logic [BANK_W-1:0]        bank_sel,
  output logic [ADDR_W+BANK_W-1:0] rom_addr,
  output logic                     ram_ce_n,
  output logic                     rom_ce_n,
  output logic                     win_ce_n,
  output logic                     win_sel
);

  localparam int WIN_SIZE = 1 << WIN_AW;
  localparam logic [ADDR_W:0] WIN_LO = {1'b0, ADDR_W'(WIN_BASE)};
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(WIN_SIZE);
  localparam logic [ADDR_W:0] ROM_LO = {1'b0, ADDR_W'(ROM_BASE)};

  region_e rgn;
  sel_t    sel;
  logic [ADDR_W:0] a_ext;

  assign a_ext = {1'b0, addr_next};

  always_comb begin
    if (!seen_next)             rgn = RGN_NONE;
    else if (a_ext < WIN_LO)    rgn = RGN_RAM;
    else if (a_ext < WIN_HI)    rgn = RGN_WIN;
    else if (a_ext >= ROM_LO)   rgn = RGN_ROM;
    else                        rgn = RGN_NONE;
  end

  assign sel = region_to_sel(rgn);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_ce_n <= 1'b1;
      rom_ce_n <= 1'b1;
      win_ce_n <= 1'b1;
      win_sel  <= 1'b0;
      rom_addr <= '0;
    end else begin
      ram_ce_n <= ~sel.ram;
      rom_ce_n <= ~sel.rom;
      win_ce_n <= ~sel.win;
      win_sel  <= sel.win;
      rom_addr <= {bank_sel, addr_next};
    end
  end

endmodule

// File: rtl/mbd_reg_window.sv
module mbd_reg_window #(
  parameter int DATA_W = 8,
  parameter int WIN_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_sel,
  input  logic [WIN_AW-1:0] offset,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_in,
  input  logic [DATA_W-1:0] rx_in,
  input  logic [DATA_W-1:0] stat_in,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] tx_q
);

  localparam int NREG = 4;
  localparam logic [WIN_AW-1:0] OFF_CFG  = WIN_AW'(0);
  localparam logic [WIN_AW-1:0] OFF_SER  = WIN_AW'(1);
  localparam logic [WIN_AW-1:0] OFF_CNT  = WIN_AW'(2);
  localparam logic [WIN_AW-1:0] OFF_STAT = WIN_AW'(3);

  logic              wr_d;
  logic              wr_rise;
  logic [NREG-1:0]   hit;
  logic [DATA_W-1:0] rd_src [NREG];
  logic [DATA_W-1:0] rd_mux;

  assign wr_rise = wr_en & ~wr_d;

  // One-hot hit per implemented offset; unused offsets leave all bits clear.
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (offset == WIN_AW'(i));
  end

  assign rd_src[0] = cfg_q;
  assign rd_src[1] = rx_in;
  assign rd_src[2] = cnt_in;
  assign rd_src[3] = stat_in;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rd_mux = rd_src[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d  <= 1'b0;
      cfg_q <= '0;
      tx_q  <= '0;
    end else begin
      wr_d <= wr_en;
      if (wr_rise && win_sel) begin
        if (offset == OFF_CFG) cfg_q <= wdata;
        if (offset == OFF_SER) tx_q  <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_en & win_sel;
      dout    <= (rd_en & win_sel) ? rd_mux : '0;
    end
  end

  // Offsets named for readability of the map; counter and status are read-only.
  logic unused_names;
  assign unused_names = ^{OFF_CNT, OFF_STAT};

endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          BANK_W   = 2,
  parameter int          WIN_AW   = 3,
  parameter logic [15:0] WIN_BASE = 16'h1FF8,
  parameter logic [15:0] ROM_BASE = 16'h2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ale,
  input  logic [ADDR_W-1:0]        ad_in,
  input  logic                     rd_en,
  input  logic                     wr_en,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic [DATA_W-1:0]        cnt_in,
  input  logic [DATA_W-1:0]        rx_in,
  input  logic [DATA_W-1:0]        stat_in,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [ADDR_W+BANK_W-1:0] rom_addr,
  output logic                     ram_ce_n,
  output logic                     rom_ce_n,
  output logic                     win_ce_n,
  output logic [DATA_W-1:0]        dout,
  output logic                     dout_oe,
  output logic [DATA_W-1:0]        cfg_out,
  output logic [DATA_W-1:0]        tx_out
);

  logic [ADDR_W-1:0] addr_next;
  logic              seen_next;
  logic              win_sel;

  mbd_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .ale       (ale),
    .bus_in    (ad_in),
    .addr_q    (mem_addr),
    .addr_next (addr_next),
    .seen_next (seen_next)
  );

  mbd_map_decode #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .WIN_AW   (WIN_AW),
    .WIN_BASE (WIN_BASE),
    .ROM_BASE (ROM_BASE)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .addr_next (addr_next),
    .seen_next (seen_next),
    .bank_sel  (bank_sel),
    .rom_addr  (rom_addr),
    .ram_ce_n  (ram_ce_n),
    .rom_ce_n  (rom_ce_n),
    .win_ce_n  (win_ce_n),
    .win_sel   (win_sel)
  );

  mbd_reg_window #(.DATA_W(DATA_W), .WIN_AW(WIN_AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .win_sel (win_sel),
    .offset  (mem_addr[WIN_AW-1:0]),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wdata   (ad_in[DATA_W-1:0]),
    .cnt_in  (cnt_in),
    .rx_in   (rx_in),
    .stat_in (stat_in),
    .dout    (dout),
    .dout_oe (dout_oe),
    .cfg_q   (cfg_out),
    .tx_q    (tx_out)
  );

endmodule

// File: rtl/mux_bus_decoder_chk.sv
module mux_bus_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter int WIN_AW = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ale,
  input logic                     rd_en,
  input logic                     wr_en,
  input logic [BANK_W-1:0]        bank_sel,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic [ADDR_W+BANK_W-1:0] rom_addr,
  input logic                     ram_ce_n,
  input logic                     rom_ce_n,
  input logic                     win_ce_n,
  input logic                     dout_oe,
  input logic [DATA_W-1:0]        cfg_out,
  input logic [DATA_W-1:0]        tx_out
);

  logic wr_seen;
  always_ff @(posedge clk) begin
    if (rst) wr_seen <= 1'b0;
    else     wr_seen <= wr_en;
  end

  logic cfg_write, tx_write;
  assign cfg_write = wr_en && !wr_seen && !win_ce_n && (mem_addr[WIN_AW-1:0] == '0);
  assign tx_write  = wr_en && !wr_seen && !win_ce_n && (mem_addr[WIN_AW-1:0] == WIN_AW'(1));

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(mem_addr));

  p_one_enable_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({~ram_ce_n, ~rom_ce_n, ~win_ce_n}) <= 1);

  p_bank_bits_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rom_addr[ADDR_W+BANK_W-1:ADDR_W] == $past(bank_sel));

  p_cfg_guard_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_write |=> $stable(cfg_out));

  p_tx_guard_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_write |=> $stable(tx_out));

  p_drive_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || win_ce_n) |=> !dout_oe);

endmodule

bind mux_bus_decoder mux_bus_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .WIN_AW(WIN_AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ale      (ale),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .bank_sel (bank_sel),
  .mem_addr (mem_addr),
  .rom_addr (rom_addr),
  .ram_ce_n (ram_ce_n),
  .rom_ce_n (rom_ce_n),
  .win_ce_n (win_ce_n),
  .dout_oe  (dout_oe),
  .cfg_out  (cfg_out),
  .tx_out   (tx_out)
);

// File: tb/sim_mux_bus_decoder.sv
module sim_mux_bus_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0;
  logic [15:0] ad_in = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  bank_sel = '0;
  logic [7:0]  cnt_in = '0, rx_in = '0, stat_in = '0;
  logic [15:0] mem_addr;
  logic [17:0] rom_addr;
  logic        ram_ce_n, rom_ce_n, win_ce_n;
  logic [7:0]  dout;
  logic        dout_oe;
  logic [7:0]  cfg_out, tx_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  m_cfg = '0, m_tx = '0;
  logic [15:0] cur_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_decoder u0 (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .rd_en(rd_en), .wr_en(wr_en),
    .bank_sel(bank_sel), .cnt_in(cnt_in), .rx_in(rx_in), .stat_in(stat_in),
    .mem_addr(mem_addr), .rom_addr(rom_addr), .ram_ce_n(ram_ce_n),
    .rom_ce_n(rom_ce_n), .win_ce_n(win_ce_n), .dout(dout), .dout_oe(dout_oe),
    .cfg_out(cfg_out), .tx_out(tx_out)
  );

  // Expected enables {ram, rom, win}, active low, from the address map.
  function automatic logic [2:0] exp_ce(input logic [15:0] a);
    if (a <= 16'h1FF7)      return 3'b011;
    else if (a <= 16'h1FFF) return 3'b110;
    else                    return 3'b101;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] off);
    case (off)
      3'd0: return m_cfg;
      3'd1: return rx_in;
      3'd2: return cnt_in;
      3'd3: return stat_in;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [15:0] a, input logic [1:0] b);
    @(negedge clk); ale = 1'b1; ad_in = a; bank_sel = b;
    @(negedge clk); ale = 1'b0; ad_in = 16'($urandom);
    @(negedge clk);
    cur_addr = a;
    check("R1 latched address", 32'(mem_addr), 32'(a));
    check("R2/R3/R4 enables", 32'({ram_ce_n, rom_ce_n, win_ce_n}), 32'(exp_ce(a)));
    check("R5 rom address", 32'(rom_addr), 32'({b, a}));
  endtask

  task automatic bus_write(input logic [7:0] d);
    logic win;
    win = (exp_ce(cur_addr) == 3'b110);
    @(negedge clk); wr_en = 1'b1; ad_in = {8'h00, d};
    @(negedge clk); ad_in = {8'h00, ~d};
    @(negedge clk); wr_en = 1'b0;
    if (win && cur_addr[2:0] == 3'd0) m_cfg = d;
    if (win && cur_addr[2:0] == 3'd1) m_tx  = d;
    @(negedge clk);
    check("R7/R8 config after write", 32'(cfg_out), 32'(m_cfg));
    check("R7/R8 transmit after write", 32'(tx_out), 32'(m_tx));
  endtask

  task automatic bus_read();
    logic win;
    win = (exp_ce(cur_addr) == 3'b110);
    cnt_in = 8'($urandom); rx_in = 8'($urandom); stat_in = 8'($urandom);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk);
    if (win) begin
      check("R9 drive enable", 32'(dout_oe), 32'd1);
      check("R9 read data", 32'(dout), 32'(exp_rd(cur_addr[2:0])));
    end else begin
      check("R10 no drive outside window", 32'(dout_oe), 32'd0);
    end
    rd_en = 1'b0;
    @(negedge clk);
    check("R10 no drive after read", 32'(dout_oe), 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6: reset state, no enable before the first strobe even with bus activity
    ad_in = 16'h0000;
    repeat (2) @(negedge clk);
    check("R6 enables idle", 32'({ram_ce_n, rom_ce_n, win_ce_n}), 32'b111);
    check("R6 drive off", 32'(dout_oe), 32'd0);
    check("R6 config reset", 32'(cfg_out), 32'd0);
    check("R6 transmit reset", 32'(tx_out), 32'd0);

    // Map edges
    latch(16'h0000, 2'd0);
    latch(16'h1FF7, 2'd1);
    latch(16'h1FF8, 2'd2);
    latch(16'h1FFF, 2'd3);
    latch(16'h2000, 2'd1);
    latch(16'hFFFF, 2'd2);

    // R7: config and transmit writes, held strobe does not rewrite
    latch(16'h1FF8, 2'd0); bus_write(8'hA5); bus_read();
    latch(16'h1FF9, 2'd0); bus_write(8'h3C); bus_read();
    // R8: read-only and unused offsets ignore writes
    for (int o = 2; o < 8; o++) begin
      latch(16'h1FF8 + 16'(o), 2'd0); bus_write(8'hFF); bus_read();
    end
    // R8/R10: outside the window
    latch(16'h0100, 2'd0); bus_write(8'h11); bus_read();
    latch(16'h8000, 2'd3); bus_write(8'h22); bus_read();

    // Random mix biased toward the window
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = ($urandom % 3 == 0) ? (16'h1FF8 + 16'($urandom % 8)) : 16'($urandom);
      latch(a, 2'($urandom));
      if ($urandom % 2 == 0) bus_write(8'($urandom));
      bus_read();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule